// File: doc/BRIEF.md
# Triple Interval Timer

This block holds three independent 32-bit counters behind a small register bus with an address, write data, a write strobe and combinational read data. Each counter owns a reload value and two compare values, and can count up or down. One shared control word enables each counter, sets its direction, and gates its interrupt. One shared pair of nine-bit registers, a sticky event register and a mask, covers every timer in groups of three bits. The three groups are ordered by timer, and within a group the order is compare 1, compare 2, overflow.

When an up-counter passes all-ones it reloads and flags overflow. Writing a reload value of `2^32 - P` therefore gives one overflow every P clocks, which suits a periodic tick. A compare hit flags an event while the counter keeps running. Software reads the current count, adds a delta and writes a compare register to get a one-shot event. A bit per timer for clock choice is stored but has no effect, since the block runs on the one system clock.

Each counter chooses one step per clock: SW_LOAD (a bus write to the count), HOLD (disabled), INC, DEC or WRAP (reload at the end of the range). The choice is made in that priority order.

Top module: `trio_timer`

## Requirements
- R1: In reset and after it, control reads 0x0A40 (timers 0 and 2 count up, only timer 2 enabled). All other registers read 0 and irq is 0, and timer 2 advances by one per clock once reset is released.
- R2: Timer n's count, reload, compare 1 and compare 2 registers sit at 0x10·n + 0x0, +0x4, +0x8 and +0xC. The value written to each one reads back unchanged.
- R3: A counter whose enable bit (control bit 3n) is 0 keeps its count. A bus write to a count register takes effect on that clock edge and wins over counting.
- R4: An enabled counter adds 1 per clock when its direction bit (control bit 9+n) is 1, and subtracts 1 per clock when that bit is 0.
- R5: An up-counter that holds all-ones loads its reload value on the next edge and sets event bit 3n+2 on that same edge. The next such wrap follows P clocks later, where reload = 2^32 - P.
- R6: A down-counter that holds 0 loads its reload value on the next edge and sets event bit 3n+2.
- R7: While enabled, a counter equal to compare 1 or compare 2 sets event bit 3n or 3n+1 on the next edge, and the counter keeps counting.
- R8: Event bits (offset 0x34) stay set until software writes them. A write replaces all nine bits, and an event on the same edge as a write is ORed on top of the written value.
- R9: irq[n] is 1 exactly when control bit 3n+2 is 1 and at least one of event bits 3n..3n+2 is set with its mask bit (offset 0x38, 1 = blocked) at 0.
- R10: Reads of any offset other than the fifteen mapped words return 0, and writes to them change nothing. Control reads back 12 bits, and the event and mask registers read back 9 bits.
- R11: Control bit 3n+1 (clock choice) is stored and reads back, and has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all counters step on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one write per clock while high |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 3 | Per-timer interrupt request |

## Verification
Two collisions are the interesting ones. The first is a software write to the event register on the edge where a counter wraps. The second is a count write on an edge where the counter would otherwise step. To provoke the first, the bench starts a counter two steps short of all-ones and issues the event write at once. The write then lands exactly on the wrap edge, and the bench expects the written bit and the overflow bit to appear together. To provoke the second, the bench writes a count while the counter runs down and expects the written value with no decrement applied.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    // word select inside a timer window (address bits 3:2)
    localparam logic [1:0] SUB_CNT  = 2'd0;
    localparam logic [1:0] SUB_LOAD = 2'd1;
    localparam logic [1:0] SUB_M1   = 2'd2;
    localparam logic [1:0] SUB_M2   = 2'd3;

    // event bit order inside a timer's three-bit group
    localparam int EV_M1  = 0;
    localparam int EV_M2  = 1;
    localparam int EV_OVF = 2;

    // per-clock action chosen for a counter
    typedef enum logic [2:0] {
        STEP_HOLD,
        STEP_SW_LOAD,
        STEP_INC,
        STEP_DEC,
        STEP_WRAP
    } step_e;
endpackage

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             up,
    input  logic             wr_cnt,
    input  logic             wr_load,
    input  logic             wr_m1,
    input  logic             wr_m2,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] load_q,
    output logic [CNT_W-1:0] m1_q,
    output logic [CNT_W-1:0] m2_q,
    output logic [2:0]       ev
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;
    localparam logic [CNT_W-1:0] CNT_BOT = '0;

    step_e            step;
    logic [CNT_W-1:0] cnt_d;

    // step selection: bus write first, then enable, then direction
    always_comb begin
        if (wr_cnt)
            step = STEP_SW_LOAD;
        else if (!en)
            step = STEP_HOLD;
        else if (up)
            step = (cnt_q == CNT_TOP) ? STEP_WRAP : STEP_INC;
        else
            step = (cnt_q == CNT_BOT) ? STEP_WRAP : STEP_DEC;
    end

    always_comb begin
        unique case (step)
            STEP_SW_LOAD: cnt_d = wdata;
            STEP_INC:     cnt_d = cnt_q + CNT_W'(1);
            STEP_DEC:     cnt_d = cnt_q - CNT_W'(1);
            STEP_WRAP:    cnt_d = load_q;
            default:      cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            load_q <= '0;
            m1_q   <= '0;
            m2_q   <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (wr_load) load_q <= wdata;
            if (wr_m1)   m1_q   <= wdata;
            if (wr_m2)   m2_q   <= wdata;
        end
    end

    always_comb begin
        ev         = '0;
        ev[EV_M1]  = en && (cnt_q == m1_q);
        ev[EV_M2]  = en && (cnt_q == m2_q);
        ev[EV_OVF] = (step == STEP_WRAP);
    end
endmodule

// File: rtl/tmr_shared.sv
`timescale 1ns/1ps
module tmr_shared #(
    parameter int NUM_TMR = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctrl_wr,
    input  logic                   stat_wr,
    input  logic                   mask_wr,
    input  logic [4*NUM_TMR-1:0]   wdata_ctrl,
    input  logic [3*NUM_TMR-1:0]   wdata_flag,
    input  logic [3*NUM_TMR-1:0]   ev,
    output logic [4*NUM_TMR-1:0]   ctrl_q,
    output logic [3*NUM_TMR-1:0]   stat_q,
    output logic [3*NUM_TMR-1:0]   mask_q,
    output logic [NUM_TMR-1:0]     irq
);
    localparam int CTRL_W = 4 * NUM_TMR;
    localparam int STAT_W = 3 * NUM_TMR;
    localparam int DIR_LO = 3 * NUM_TMR;

    // first and last timer count up, only the last one runs
    function automatic logic [CTRL_W-1:0] ctrl_init();
        logic [CTRL_W-1:0] v;
        v = '0;
        v[DIR_LO]                 = 1'b1;
        v[DIR_LO + NUM_TMR - 1]   = 1'b1;
        v[3 * (NUM_TMR - 1)]      = 1'b1;
        return v;
    endfunction

    localparam logic [CTRL_W-1:0] CTRL_RST = ctrl_init();

    logic [STAT_W-1:0] stat_d;

    always_comb begin
        stat_d = (stat_wr ? wdata_flag : stat_q) | ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= wdata_ctrl;
            if (mask_wr) mask_q <= wdata_flag;
            stat_q <= stat_d;
        end
    end

    for (genvar n = 0; n < NUM_TMR; n++) begin : g_irq
        assign irq[n] = ctrl_q[3*n+2] & (|(stat_q[3*n +: 3] & ~mask_q[3*n +: 3]));
    end
endmodule

// File: rtl/trio_timer.sv
`timescale 1ns/1ps
module trio_timer
    import tmr_pkg::*;
#(
    parameter int NUM_TMR = 3,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [CNT_W-1:0]   bus_wdata,
    input  logic               bus_wr,
    output logic [CNT_W-1:0]   bus_rdata,
    output logic [NUM_TMR-1:0] irq
);
    localparam int STAT_W  = 3 * NUM_TMR;
    localparam int CTRL_W  = 4 * NUM_TMR;
    localparam int WIN_W   = ADDR_W - 4;
    localparam int SH_BASE = 16 * NUM_TMR;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(SH_BASE);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(SH_BASE + 4);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(SH_BASE + 8);

    logic              aligned;
    logic [1:0]        sub;
    logic [WIN_W-1:0]  win;
    logic              ctrl_wr, stat_wr, mask_wr;
    logic [CTRL_W-1:0] ctrl_q;
    logic [STAT_W-1:0] stat_q, mask_q, evts;
    logic [NUM_TMR-1:0] win_hit, cnt_wr;
    logic [NUM_TMR-1:0][CNT_W-1:0] cnt_q, load_q, m1_q, m2_q;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign sub     = bus_addr[3:2];
    assign win     = bus_addr[ADDR_W-1:4];
    assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
    assign stat_wr = bus_wr && (bus_addr == A_STAT);
    assign mask_wr = bus_wr && (bus_addr == A_MASK);

    for (genvar n = 0; n < NUM_TMR; n++) begin : g_tmr
        assign win_hit[n] = aligned && (win == WIN_W'(n));
        assign cnt_wr[n]  = bus_wr && win_hit[n] && (sub == SUB_CNT);

        tmr_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (ctrl_q[3*n]),
            .up      (ctrl_q[3*NUM_TMR + n]),
            .wr_cnt  (cnt_wr[n]),
            .wr_load (bus_wr && win_hit[n] && (sub == SUB_LOAD)),
            .wr_m1   (bus_wr && win_hit[n] && (sub == SUB_M1)),
            .wr_m2   (bus_wr && win_hit[n] && (sub == SUB_M2)),
            .wdata   (bus_wdata),
            .cnt_q   (cnt_q[n]),
            .load_q  (load_q[n]),
            .m1_q    (m1_q[n]),
            .m2_q    (m2_q[n]),
            .ev      (evts[3*n +: 3])
        );
    end

    tmr_shared #(.NUM_TMR(NUM_TMR)) u_shared (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .stat_wr    (stat_wr),
        .mask_wr    (mask_wr),
        .wdata_ctrl (bus_wdata[CTRL_W-1:0]),
        .wdata_flag (bus_wdata[STAT_W-1:0]),
        .ev         (evts),
        .ctrl_q     (ctrl_q),
        .stat_q     (stat_q),
        .mask_q     (mask_q),
        .irq        (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL)      bus_rdata = CNT_W'(ctrl_q);
        else if (bus_addr == A_STAT) bus_rdata = CNT_W'(stat_q);
        else if (bus_addr == A_MASK) bus_rdata = CNT_W'(mask_q);
        else begin
            for (int n = 0; n < NUM_TMR; n++) begin
                if (win_hit[n]) begin
                    unique case (sub)
                        SUB_CNT:  bus_rdata = cnt_q[n];
                        SUB_LOAD: bus_rdata = load_q[n];
                        SUB_M1:   bus_rdata = m1_q[n];
                        default:  bus_rdata = m2_q[n];
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/trio_timer_chk.sv
`timescale 1ns/1ps
module trio_timer_chk #(
    parameter int NUM_TMR = 3,
    parameter int CNT_W   = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [4*NUM_TMR-1:0]          ctrl_q,
    input logic [3*NUM_TMR-1:0]          stat_q,
    input logic [3*NUM_TMR-1:0]          mask_q,
    input logic [NUM_TMR-1:0]            irq,
    input logic [NUM_TMR-1:0]            cnt_wr,
    input logic                          stat_wr,
    input logic [NUM_TMR-1:0][CNT_W-1:0] cnt_q,
    input logic [NUM_TMR-1:0][CNT_W-1:0] load_q
);
    localparam logic [CNT_W-1:0] TOP = '1;

    for (genvar n = 0; n < NUM_TMR; n++) begin : g_t
        // R3
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl_q[3*n] && !cnt_wr[n]) |=> $stable(cnt_q[n]));
        // R4
        up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_q[3*n] && ctrl_q[3*NUM_TMR+n] && !cnt_wr[n] && cnt_q[n] != TOP)
            |=> (cnt_q[n] == $past(cnt_q[n]) + CNT_W'(1)));
        // R4
        down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_q[3*n] && !ctrl_q[3*NUM_TMR+n] && !cnt_wr[n] && cnt_q[n] != '0)
            |=> (cnt_q[n] == $past(cnt_q[n]) - CNT_W'(1)));
        // R5
        up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_q[3*n] && ctrl_q[3*NUM_TMR+n] && !cnt_wr[n] && cnt_q[n] == TOP)
            |=> (cnt_q[n] == $past(load_q[n]) && stat_q[3*n+2]));
        // R6
        down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_q[3*n] && !ctrl_q[3*NUM_TMR+n] && !cnt_wr[n] && cnt_q[n] == '0)
            |=> (cnt_q[n] == $past(load_q[n]) && stat_q[3*n+2]));
        // R9
        irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl_q[3*n+2] |-> !irq[n]);
        // R9
        irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[n] |-> (|(stat_q[3*n +: 3] & ~mask_q[3*n +: 3])));
    end

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

bind trio_timer trio_timer_chk #(.NUM_TMR(NUM_TMR), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_q  (ctrl_q),
    .stat_q  (stat_q),
    .mask_q  (mask_q),
    .irq     (irq),
    .cnt_wr  (cnt_wr),
    .stat_wr (stat_wr),
    .cnt_q   (cnt_q),
    .load_q  (load_q)
);

// File: tb/test_trio_timer.sv
`timescale 1ns/1ps
module test_trio_timer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_wr;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    trio_timer i_trio_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'h00, 32'h12345678, 32'h12345678, 8'd2},  // R2 count 0
        '{1'b1, 8'h04, 32'h0BADF00D, 32'h0BADF00D, 8'd2},  // R2 reload 0
        '{1'b1, 8'h08, 32'h00000011, 32'h00000011, 8'd2},  // R2 compare 1
        '{1'b1, 8'h0C, 32'h00000011, 32'h00000011, 8'd2},  // R2 compare 2
        '{1'b1, 8'h14, 32'hA5A5A5A5, 32'hA5A5A5A5, 8'd2},  // R2 reload 1
        '{1'b1, 8'h28, 32'h5A5A0001, 32'h5A5A0001, 8'd2},  // R2 compare 1 of timer 2
        '{1'b1, 8'h2C, 32'hCAFE0002, 32'hCAFE0002, 8'd2},  // R2 compare 2 of timer 2
        '{1'b1, 8'h38, 32'hFFFFFFFF, 32'h000001FF, 8'd10}, // R10 mask width
        '{1'b1, 8'h38, 32'h00000000, 32'h00000000, 8'd10},
        '{1'b1, 8'h30, 32'hFFFF0092, 32'h00000092, 8'd11}, // R11 clock bits kept
        '{1'b1, 8'h30, 32'h00000000, 32'h00000000, 8'd11},
        '{1'b1, 8'h3C, 32'hDEADBEEF, 32'h00000000, 8'd10}, // R10 hole
        '{1'b1, 8'h40, 32'hFFFFFFFF, 32'h00000000, 8'd10}, // R10 beyond map
        '{1'b0, 8'h00, 32'h00000000, 32'h12345678, 8'd10}, // R10 stray writes harmless
        '{1'b1, 8'h34, 32'hFFFFFFFF, 32'h000001FF, 8'd8},  // R8 write replaces
        '{1'b1, 8'h34, 32'h00000000, 32'h00000000, 8'd8}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v, v2;
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        wait_n(3);
        // R1 reset state
        rd(8'h30, v); chk("R1 control", v, 32'h00000A40);
        rd(8'h34, v); chk("R1 status", v, 32'h0);
        rd(8'h38, v); chk("R1 mask", v, 32'h0);
        rd(8'h20, v); chk("R1 count 2", v, 32'h0);
        chk("R1 irq", {29'b0, irq}, 32'h0);
        rst_n = 1'b1;
        rd(8'h20, v);
        wait_n(3);
        rd(8'h20, v2); chk("R1 timer 2 runs", v2, v + 32'd3);

        wr(8'h30, 32'h0);
        wr(8'h34, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
            rd(VEC[i].addr, v);
            chk($sformatf("R%0d table %0d", VEC[i].req, i), v, VEC[i].exp);
        end

        // R4 up count, with clock bit set (R11)
        wr(8'h00, 32'd100);
        wr(8'h30, 32'h203);
        wait_n(5);
        rd(8'h00, v); chk("R4 up count R11", v, 32'd105);
        // R3 hold when disabled
        wr(8'h30, 32'h0);
        rd(8'h00, v);
        wait_n(5);
        rd(8'h00, v2); chk("R3 hold", v2, v);
        // R4 down count
        wr(8'h00, 32'd50);
        wr(8'h30, 32'h001);
        wait_n(7);
        rd(8'h00, v); chk("R4 down count", v, 32'd43);
        // R3 write wins over counting
        wr(8'h00, 32'd1000);
        rd(8'h00, v); chk("R3 write wins", v, 32'd1000);

        // R5 up wrap every 4 clocks
        wr(8'h30, 32'h0);
        wr(8'h34, 32'h0);
        wr(8'h04, 32'hFFFFFFFC);
        wr(8'h00, 32'hFFFFFFFD);
        wr(8'h30, 32'h201);
        wait_n(2);
        rd(8'h00, v); chk("R5 before wrap count", v, 32'hFFFFFFFF);
        rd(8'h34, v); chk("R5 before wrap flag", v, 32'h0);
        wait_n(1);
        rd(8'h00, v); chk("R5 reload", v, 32'hFFFFFFFC);
        rd(8'h34, v); chk("R5 overflow flag", v, 32'h004);
        wr(8'h34, 32'h0);
        wait_n(1);
        rd(8'h34, v); chk("R5 cleared", v, 32'h0);
        wait_n(1);
        rd(8'h34, v); chk("R5 period 4", v, 32'h004);

        // R6 down wrap
        wr(8'h30, 32'h0);
        wr(8'h34, 32'h0);
        wr(8'h04, 32'd5);
        wr(8'h00, 32'd2);
        wr(8'h30, 32'h001);
        wait_n(2);
        rd(8'h00, v); chk("R6 at zero", v, 32'd0);
        rd(8'h34, v); chk("R6 no flag yet", v, 32'h0);
        wait_n(1);
        rd(8'h00, v); chk("R6 reload", v, 32'd5);
        rd(8'h34, v); chk("R6 overflow flag", v, 32'h004);

        // R7 compare hits on timer 1
        wr(8'h30, 32'h0);
        wr(8'h34, 32'h0);
        wr(8'h10, 32'd10);
        wr(8'h18, 32'd13);
        wr(8'h1C, 32'd15);
        wr(8'h30, 32'h408);
        wait_n(3);
        rd(8'h34, v); chk("R7 before hit", v, 32'h0);
        wait_n(1);
        rd(8'h34, v); chk("R7 compare 1", v, 32'h008);
        rd(8'h10, v); chk("R7 keeps running", v, 32'd14);
        wait_n(2);
        rd(8'h34, v); chk("R7 compare 2", v, 32'h018);

        // R9 interrupt gating and mask
        #1; chk("R9 gated off", {29'b0, irq}, 32'h0);
        wr(8'h30, 32'h428);
        #1; chk("R9 raised", {29'b0, irq}, 32'h2);
        wr(8'h38, 32'h018);
        #1; chk("R9 masked", {29'b0, irq}, 32'h0);
        wr(8'h38, 32'h010);
        #1; chk("R9 one unmasked", {29'b0, irq}, 32'h2);
        wr(8'h34, 32'h0);
        #1; chk("R9 cleared R8", {29'b0, irq}, 32'h0);
        wr(8'h30, 32'h0);
        wr(8'h38, 32'h0);

        // R8 event and write on the same edge
        wr(8'h04, 32'hFFFFFFF0);
        wr(8'h00, 32'hFFFFFFFE);
        wr(8'h30, 32'h201);
        wr(8'h34, 32'h100);
        rd(8'h34, v); chk("R8 same edge", v, 32'h104);
        wait_n(4);
        rd(8'h34, v); chk("R8 sticky", v, 32'h104);

        done = 1'b1;
        finish_run();
    end
endmodule